// File: doc/BRIEF.md
# ROM Table Lookup Sequencer

This block carries out a page-relative table read for a small 4-bit controller core. When the core presents the table-read opcode, the sequencer parks the current program counter on a hardware return stack. It then points the program counter at a ROM location and reads one 10-bit ROM word. The word is split into the B and A nibble registers, and in one mode it also updates the address register D. Finally the program counter is popped back from the stack. The whole instruction takes three machine cycles. During those cycles `busy` stalls the surrounding fetch logic, and `done` marks the last cycle.

The ROM location is built from three parts. The page number in the low bits of the opcode becomes the upper program-counter part. D2..D0 supply the upper three bits of the 7-bit low part, and A3..A0 supply its lower four bits. The ROM answers one cycle after the address is presented. The register results are written in the cycle after that read. The surrounding core can load the stack pointer while the sequencer is idle. A push past the last stack entry wraps the pointer and sets a sticky overflow flag.

Top module: `rom_lookup_top`

## Requirements
- R1: A word is accepted only when `instrValid` is high, the sequencer is idle, and `instrWord[9:6]` equals 4'b0010. Any other word leaves `busy`, `spOut`, `regBOut`, `regAOut` and `regDOut` unchanged.
- R2: After the accepting clock edge, `busy` is high for exactly three cycles. `done` is high only in the third of them.
- R3: In the first busy cycle, `romRdEn` is high. `spOut` equals the old stack pointer plus one (modulo `STACK_DEPTH`). `romAddr` equals {page, D2..D0, A3..A0}, where the page is `instrWord` masked to `PAGE_COUNT` pages.
- R4: In the third busy cycle, `regBOut` holds ROM bits 7..4, `regAOut` holds ROM bits 3..0, and `abWrite` is high.
- R5: With `modeFlag`=0 at acceptance, `regDOut` becomes {0, D1, D0}. With `modeFlag`=1 it becomes {D2, ROM bit 9, ROM bit 8}. `dWrite` is high in the third busy cycle.
- R6: In the cycle after `done`, `pcOut` equals the `pcIn` value captured at acceptance, and `spOut` is back to its value before the instruction.
- R7: A push while `spOut` equals `STACK_DEPTH`-1 wraps the pointer to 0 and sets `stackOvf`. The flag stays set until reset, and the program counter is still restored correctly.
- R8: While idle, `spWrEn` loads `spWrData` into the stack pointer. While busy, both `spWrEn` and `instrValid` are ignored.
- R9: After reset, `busy`, `done`, `stackOvf`, `spOut` and `pcOut` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instrValid | input | 1 | Decoded instruction word is present |
| instrWord | input | 10 | Instruction word; bits 9..6 opcode, bits 5..0 page |
| regAIn | input | 4 | Current A register |
| regDIn | input | 3 | Current D register |
| modeFlag | input | 1 | 1: ROM bits 9..8 also go to D1..D0 |
| pcIn | input | 13 | Program counter to be saved |
| spWrEn | input | 1 | Load stack pointer (idle only) |
| spWrData | input | 3 | Stack pointer load value |
| romData | input | 10 | Synchronous ROM read data |
| busy | output | 1 | Sequencer occupied, stall fetch |
| done | output | 1 | Final cycle of the instruction |
| romRdEn | output | 1 | ROM read request |
| romAddr | output | 13 | ROM address {page, D, A} |
| regBOut | output | 4 | New B register value |
| regAOut | output | 4 | New A register value |
| regDOut | output | 3 | New D register value |
| abWrite | output | 1 | Write strobe for A and B |
| dWrite | output | 1 | Write strobe for D |
| pcOut | output | 13 | Program counter, restored after the instruction |
| spOut | output | 3 | Stack pointer |
| stackOvf | output | 1 | Sticky stack overflow flag |

## Verification
The ROM address and the pushed stack pointer are due one cycle after the accepting edge. The B, A and D results and their write strobes are due three cycles after it. The restored program counter and popped pointer are due four cycles after it. The bench drives each stimulus on a falling edge and then samples on the falling edge of each following cycle, so every result is read half a cycle after the rising edge that produces it. The sweep covers every page, A and D value in both modes, and compares against an arithmetic ROM function that the bench also uses as its ROM model.

// File: rtl/rom_lookup_pkg.sv
package rom_lookup_pkg;
  localparam int INSTR_W = 10;
  localparam int NIB_W = 4;
  localparam int DREG_W = 3;
  localparam int OPC_W = 4;
  localparam int LOW_W = DREG_W + NIB_W;
  localparam logic [OPC_W-1:0] OPC_TABLE = 4'b0010;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ADDR,
    ST_LOAD,
    ST_RESTORE
  } seqState_t;

  typedef struct packed {
    logic accept;
    logic latchRom;
    logic restore;
  } seqStrobe_t;
endpackage

// File: rtl/rom_lookup_ctrl.sv
module rom_lookup_ctrl
  import rom_lookup_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             instrValid,
  input  logic [OPC_W-1:0] opcField,
  output seqStrobe_t       strobe,
  output logic             busy,
  output logic             done,
  output logic             romRdEn,
  output logic             abWrite,
  output logic             dWrite
);
  seqState_t state, stateNext;
  logic isMatch;

  assign isMatch = instrValid && (opcField == OPC_TABLE);

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:    if (isMatch) stateNext = ST_ADDR;
      ST_ADDR:    stateNext = ST_LOAD;
      ST_LOAD:    stateNext = ST_RESTORE;
      ST_RESTORE: stateNext = ST_IDLE;
      default:    stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strobe.accept   = (state == ST_IDLE) && isMatch;
    strobe.latchRom = (state == ST_LOAD);
    strobe.restore  = (state == ST_RESTORE);
  end

  assign busy    = (state != ST_IDLE);
  assign done    = (state == ST_RESTORE);
  assign romRdEn = (state == ST_ADDR);
  assign abWrite = (state == ST_RESTORE);
  assign dWrite  = (state == ST_RESTORE);
endmodule

// File: rtl/rom_lookup_dp.sv
module rom_lookup_dp
  import rom_lookup_pkg::*;
#(
  parameter int PAGE_COUNT  = 64,
  parameter int STACK_DEPTH = 8,
  localparam int PAGE_W = $clog2(PAGE_COUNT),
  localparam int PC_W   = PAGE_W + LOW_W,
  localparam int SP_W   = $clog2(STACK_DEPTH)
) (
  input  logic               clk,
  input  logic               rstN,
  input  seqStrobe_t         strobe,
  input  logic               busy,
  input  logic [PAGE_W-1:0]  pageField,
  input  logic [NIB_W-1:0]   regAIn,
  input  logic [DREG_W-1:0]  regDIn,
  input  logic               modeFlag,
  input  logic [PC_W-1:0]    pcIn,
  input  logic               spWrEn,
  input  logic [SP_W-1:0]    spWrData,
  input  logic [INSTR_W-1:0] romData,
  output logic [PC_W-1:0]    romAddr,
  output logic [NIB_W-1:0]   regBOut,
  output logic [NIB_W-1:0]   regAOut,
  output logic [DREG_W-1:0]  regDOut,
  output logic [PC_W-1:0]    pcOut,
  output logic [SP_W-1:0]    spOut,
  output logic               stackOvf
);
  localparam logic [SP_W-1:0] SP_TOP = SP_W'(STACK_DEPTH - 1);

  logic [PC_W-1:0]   stackMem [STACK_DEPTH];
  logic [PC_W-1:0]   pcReg;
  logic [SP_W-1:0]   spReg, spInc, spDec;
  logic              ovfReg, modeHeld;
  logic [DREG_W-1:0] dHeld;
  logic [NIB_W-1:0]  bReg, aReg;
  logic [DREG_W-1:0] dReg;
  logic [DREG_W-1:0] dNew;

  assign spInc = (spReg == SP_TOP) ? '0 : spReg + 1'b1;
  assign spDec = (spReg == '0) ? SP_TOP : spReg - 1'b1;

  always_comb begin
    if (modeHeld) dNew = {dHeld[DREG_W-1], romData[INSTR_W-1:INSTR_W-2]};
    else          dNew = {1'b0, dHeld[DREG_W-2:0]};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcReg    <= '0;
      spReg    <= '0;
      ovfReg   <= 1'b0;
      modeHeld <= 1'b0;
      dHeld    <= '0;
    end else if (strobe.accept) begin
      spReg    <= spInc;
      pcReg    <= {pageField, regDIn, regAIn};
      dHeld    <= regDIn;
      modeHeld <= modeFlag;
      if (spReg == SP_TOP) ovfReg <= 1'b1;
    end else if (strobe.restore) begin
      pcReg <= stackMem[spReg];
      spReg <= spDec;
    end else if (spWrEn && !busy) begin
      spReg <= spWrData;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.accept) stackMem[spInc] <= pcIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bReg <= '0;
      aReg <= '0;
      dReg <= '0;
    end else if (strobe.latchRom) begin
      bReg <= romData[2*NIB_W-1:NIB_W];
      aReg <= romData[NIB_W-1:0];
      dReg <= dNew;
    end
  end

  assign romAddr  = pcReg;
  assign pcOut    = pcReg;
  assign spOut    = spReg;
  assign stackOvf = ovfReg;
  assign regBOut  = bReg;
  assign regAOut  = aReg;
  assign regDOut  = dReg;
endmodule

// File: rtl/rom_lookup_top.sv
module rom_lookup_top
  import rom_lookup_pkg::*;
#(
  parameter int PAGE_COUNT  = 64,
  parameter int STACK_DEPTH = 8,
  localparam int PAGE_W = $clog2(PAGE_COUNT),
  localparam int PC_W   = PAGE_W + LOW_W,
  localparam int SP_W   = $clog2(STACK_DEPTH)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               instrValid,
  input  logic [INSTR_W-1:0] instrWord,
  input  logic [NIB_W-1:0]   regAIn,
  input  logic [DREG_W-1:0]  regDIn,
  input  logic               modeFlag,
  input  logic [PC_W-1:0]    pcIn,
  input  logic               spWrEn,
  input  logic [SP_W-1:0]    spWrData,
  input  logic [INSTR_W-1:0] romData,
  output logic               busy,
  output logic               done,
  output logic               romRdEn,
  output logic [PC_W-1:0]    romAddr,
  output logic [NIB_W-1:0]   regBOut,
  output logic [NIB_W-1:0]   regAOut,
  output logic [DREG_W-1:0]  regDOut,
  output logic               abWrite,
  output logic               dWrite,
  output logic [PC_W-1:0]    pcOut,
  output logic [SP_W-1:0]    spOut,
  output logic               stackOvf
);
  seqStrobe_t strobe;

  rom_lookup_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .instrValid(instrValid),
    .opcField(instrWord[INSTR_W-1:INSTR_W-OPC_W]),
    .strobe(strobe), .busy(busy), .done(done), .romRdEn(romRdEn),
    .abWrite(abWrite), .dWrite(dWrite)
  );

  rom_lookup_dp #(.PAGE_COUNT(PAGE_COUNT), .STACK_DEPTH(STACK_DEPTH)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busy(busy),
    .pageField(instrWord[PAGE_W-1:0]), .regAIn(regAIn), .regDIn(regDIn),
    .modeFlag(modeFlag), .pcIn(pcIn), .spWrEn(spWrEn), .spWrData(spWrData),
    .romData(romData), .romAddr(romAddr), .regBOut(regBOut),
    .regAOut(regAOut), .regDOut(regDOut), .pcOut(pcOut), .spOut(spOut),
    .stackOvf(stackOvf)
  );
endmodule

// File: rtl/rom_lookup_chk.sv
module rom_lookup_chk #(
  parameter int STACK_DEPTH = 8,
  localparam int SP_W = $clog2(STACK_DEPTH)
) (
  input logic            clk,
  input logic            rstN,
  input logic            busy,
  input logic            done,
  input logic            romRdEn,
  input logic            abWrite,
  input logic [SP_W-1:0] spOut,
  input logic            stackOvf
);
  localparam logic [SP_W-1:0] SP_TOP = SP_W'(STACK_DEPTH - 1);

  a_r2_done_inside_busy: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy);

  a_r2_busy_three: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |=> busy ##1 busy ##1 !busy);

  a_r3_rom_read_first: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> romRdEn);

  a_r3_push_sp: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> spOut == (($past(spOut) == SP_TOP) ? '0 : $past(spOut) + 1'b1));

  a_r4_write_in_done: assert property (@(posedge clk) disable iff (!rstN)
    abWrite |-> done);

  a_r6_pop_sp: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> spOut == (($past(spOut) == '0) ? SP_TOP : $past(spOut) - 1'b1));

  a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rstN)
    stackOvf |=> stackOvf);

  a_r8_sp_hold_busy: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(spOut));
endmodule

bind rom_lookup_top rom_lookup_chk #(.STACK_DEPTH(STACK_DEPTH)) chk_i (
  .clk(clk), .rstN(rstN), .busy(busy), .done(done), .romRdEn(romRdEn),
  .abWrite(abWrite), .spOut(spOut), .stackOvf(stackOvf)
);

// File: tb/rom_lookup_top_tb_top.sv
`timescale 1ns/1ps
module rom_lookup_top_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic instrValid = 1'b0;
  logic [9:0] instrWord = '0;
  logic [3:0] regAIn = '0;
  logic [2:0] regDIn = '0;
  logic modeFlag = 1'b0;
  logic [12:0] pcIn = '0;
  logic spWrEn = 1'b0;
  logic [2:0] spWrData = '0;
  logic [9:0] romData;
  logic busy, done, romRdEn, abWrite, dWrite, stackOvf;
  logic [12:0] romAddr, pcOut;
  logic [3:0] regBOut, regAOut;
  logic [2:0] regDOut, spOut;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 0;
  int spModel = 0;

  always #4 clk = ~clk;

  rom_lookup_top dut_i (
    .clk(clk), .rstN(rstN), .instrValid(instrValid), .instrWord(instrWord),
    .regAIn(regAIn), .regDIn(regDIn), .modeFlag(modeFlag), .pcIn(pcIn),
    .spWrEn(spWrEn), .spWrData(spWrData), .romData(romData), .busy(busy),
    .done(done), .romRdEn(romRdEn), .romAddr(romAddr), .regBOut(regBOut),
    .regAOut(regAOut), .regDOut(regDOut), .abWrite(abWrite), .dWrite(dWrite),
    .pcOut(pcOut), .spOut(spOut), .stackOvf(stackOvf)
  );

  function automatic logic [9:0] romFn(input logic [12:0] addr);
    int v;
    v = int'(addr) * 37 + (int'(addr) >> 4) * 11 + 7;
    return v[9:0];
  endfunction

  always_ff @(posedge clk) begin
    if (romRdEn) romData <= romFn(romAddr);
  end

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic runOp(input int page, input int a, input int d, input bit mode,
                       input int pc, input bit disturb);
    logic [12:0] expAddr;
    logic [9:0]  w;
    int expD, spOld, spPush;
    expAddr = {6'(page), 3'(d), 4'(a)};
    w = romFn(expAddr);
    expD = mode ? ((d & 4) | int'(w[9:8])) : (d & 3);
    spOld = spModel;
    spPush = (spOld + 1) % 8;
    @(negedge clk);
    instrValid = 1'b1; instrWord = 10'h080 | 10'(page);
    regAIn = 4'(a); regDIn = 3'(d); modeFlag = mode; pcIn = 13'(pc);
    @(negedge clk);
    instrValid = 1'b0;
    chk("R2 busy c1", busy, 1);
    chk("R2 done c1", done, 0);
    chk("R3 romRdEn", romRdEn, 1);
    chk("R3 romAddr", romAddr, expAddr);
    chk("R3 sp push", spOut, spPush);
    if (disturb) begin
      spWrEn = 1'b1; spWrData = 3'(spOld ^ 5);
      instrValid = 1'b1; instrWord = 10'h080;
    end
    @(negedge clk);
    chk("R2 busy c2", busy, 1);
    chk("R2 done c2", done, 0);
    spWrEn = 1'b0; instrValid = 1'b0;
    @(negedge clk);
    chk("R2 done c3", done, 1);
    chk("R4 abWrite", abWrite, 1);
    chk("R4 regB", regBOut, int'(w[7:4]));
    chk("R4 regA", regAOut, int'(w[3:0]));
    chk("R5 dWrite", dWrite, 1);
    chk("R5 regD", regDOut, expD);
    @(negedge clk);
    chk("R2 busy end", busy, 0);
    chk("R6 pc restore", pcOut, pc & 13'h1fff);
    chk(disturb ? "R8 sp ignored busy" : "R6 sp pop", spOut, spOld);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk("R9 busy", busy, 0);
    chk("R9 done", done, 0);
    chk("R9 ovf", stackOvf, 0);
    chk("R9 sp", spOut, 0);
    chk("R9 pc", pcOut, 0);

    // R1: non-matching words ignored
    runOp(5, 3, 2, 1'b1, 123, 1'b0);
    for (int k = 0; k < 16; k++) begin
      if (k == 2) continue;
      @(negedge clk);
      instrValid = 1'b1; instrWord = 10'((k << 6) | 9);
      @(negedge clk);
      instrValid = 1'b0;
      chk("R1 busy", busy, 0);
      chk("R1 sp", spOut, spModel);
      @(negedge clk);
      chk("R1 regB", regBOut, int'(romFn({6'd5, 3'd2, 4'd3}) >> 4) & 15);
      chk("R1 regD", regDOut, (2 & 4) | int'(romFn({6'd5, 3'd2, 4'd3}) >> 8));
    end

    // R3 R4 R5 R6 full sweep
    for (int m = 0; m < 2; m++)
      for (int p = 0; p < 64; p++)
        for (int d = 0; d < 8; d++)
          for (int a = 0; a < 16; a++)
            runOp(p, a, d, m[0], (p * 977 + d * 131 + a * 17 + m) & 13'h1fff, 1'b0);

    chk("R7 no ovf yet", stackOvf, 0);

    // R8: idle stack pointer load, and ignore while busy
    @(negedge clk);
    spWrEn = 1'b1; spWrData = 3'd4;
    @(negedge clk);
    spWrEn = 1'b0;
    spModel = 4;
    chk("R8 sp load", spOut, 4);
    runOp(17, 9, 6, 1'b0, 4321, 1'b1);

    // R7: overflow wrap
    @(negedge clk);
    spWrEn = 1'b1; spWrData = 3'd7;
    @(negedge clk);
    spWrEn = 1'b0;
    spModel = 7;
    runOp(40, 12, 5, 1'b1, 7777, 1'b0);
    chk("R7 ovf set", stackOvf, 1);
    @(negedge clk);
    spWrEn = 1'b1; spWrData = 3'd2;
    @(negedge clk);
    spWrEn = 1'b0;
    spModel = 2;
    runOp(63, 15, 7, 1'b0, 8191, 1'b0);
    chk("R7 ovf sticky", stackOvf, 1);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule